// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Programmable Deadtime

This block turns two switching commands into the two gate-enable signals of a half-bridge. The high-side command is active high and the low-side command is active low. Because the polarities are opposite, one control signal wired to both inputs gives complementary switching. A command pair that asks for both switches at once is refused outright, and both gates are held off.

Whenever one gate turns off, the block waits a run-time programmable number of clock cycles before it lets the other gate turn on. This idle gap is also inserted when both command edges arrive in the same cycle. If the gate has already been idle for at least that long, a new request is honoured on the next clock edge with no extra delay.

Two force-off inputs, a shutdown request and an undervoltage-lockout flag, pull both gates low in the same cycle without waiting for a clock edge. On release, the idle gap is counted again before either gate may turn on.

The controller is a four-state machine:
- IDLE: both gates are off and the idle gap is being counted.
- HI_ON: the high-side gate is on.
- LO_ON: the low-side gate is on.
- HALT: the block is forced off.

The transitions are:
- arm_hi: IDLE to HI_ON, on a high-side request once the gap has elapsed.
- arm_lo: IDLE to LO_ON, on a low-side request once the gap has elapsed.
- release_hi: HI_ON to IDLE, when the high-side request goes away.
- release_lo: LO_ON to IDLE, when the low-side request goes away.
- trip: any state to HALT, while a force-off input is active.
- resume: HALT to IDLE, when both force-off inputs are clear.

Top module: `hb_gate_interlock`

## Requirements
- R1: With no force-off active and the gap elapsed, a command pair of high-side input 1 with low-side input 1 turns on only `hi_gate`, and a pair of high-side input 0 with low-side input 0 turns on only `lo_gate`. Each gate follows its command one clock edge after the command is sampled, and drops one edge after the command is withdrawn.
- R2: The clash pair (high-side input 1, low-side input 0) leaves both gates low after the next edge.
- R3: The neutral pair (high-side input 0, low-side input 1) leaves both gates low after the next edge.
- R4: `hi_gate` and `lo_gate` are never high at the same time.
- R5: After a gate turns off at edge t, neither gate turns on before edge t+D. Here D = `dt_cycles` when that value is nonzero, and D = 1 when it is zero. A request held continuously turns the other gate on at exactly edge t+D, including when both command edges coincide.
- R6: A `dt_cycles` value of 0 still gives exactly one idle cycle between one gate turning off and the other turning on.
- R7: If both gates have already been low for at least D edges, a new request turns its gate on at the first edge that samples it.
- R8: While `shutdown_in` or `uvlo_in` is high, both gates are low, and this takes effect in the same cycle the input rises, without waiting for a clock edge.
- R9: After the last force-off edge, both gates stay low for at least one further edge. The first turn-on comes no earlier than D edges after the first unforced edge.
- R10: With both command inputs tied to one signal, a high level drives `hi_gate` and a low level drives `lo_gate`, with the R5 gap inserted at every change of level.
- R11: During reset both gates are low. After reset the block starts idle, and the first turn-on occurs at the D-th edge after release at the earliest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dt_cycles | input | DT_W | Idle-gap length in clock cycles, read every cycle; 0 behaves as 1 |
| hi_cmd | input | 1 | High-side command, active high |
| lo_cmd_n | input | 1 | Low-side command, active low |
| shutdown_in | input | 1 | Shutdown request, active high, forces both gates low |
| uvlo_in | input | 1 | Undervoltage lockout flag, active high, forces both gates low |
| hi_gate | output | 1 | High-side gate enable |
| lo_gate | output | 1 | Low-side gate enable |

## Verification
Command-driven results appear one rising edge after the command is sampled. A turn-on that follows a turn-off at edge t appears D edges later. The force-off inputs act with no edge at all. The bench changes inputs 1 ns after a rising edge and reads the gates 1 ns after the following rising edge, so each reading matches one model update. The model tracks the edge at which the gates last went idle and compares elapsed edges against D, taking D from the live `dt_cycles` value. Same-cycle force-off checks are read 1 ns after the force input changes, before any further edge.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    // Controller states of the half-bridge interlock
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HI_ON = 2'd1,
        ST_LO_ON = 2'd2,
        ST_HALT  = 2'd3
    } hbd_state_e;

    // Decoded meaning of the command pair
    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_HI    = 2'd1,
        REQ_LO    = 2'd2,
        REQ_CLASH = 2'd3
    } hbd_req_e;

endpackage

// File: rtl/hbd_req_decode.sv
module hbd_req_decode
    import hbd_pkg::*;
(
    input  logic     hi_cmd,
    input  logic     lo_cmd_n,
    output hbd_req_e req
);

    // High-side is active high, low-side is active low.
    always_comb begin
        unique case ({hi_cmd, lo_cmd_n})
            2'b11:   req = REQ_HI;
            2'b00:   req = REQ_LO;
            2'b10:   req = REQ_CLASH;
            default: req = REQ_NONE;
        endcase
    end

endmodule

// File: rtl/hbd_gap_timer.sv
module hbd_gap_timer #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_clr,
    input  logic [DT_W-1:0] dt_cycles,
    output logic            gap_met
);

    localparam int EXT_W = DT_W + 1;
    localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

    logic [DT_W-1:0]  cnt_q;
    logic [EXT_W-1:0] dt_eff;
    logic [EXT_W-1:0] elapsed;

    // Zero programmed gap still yields one idle cycle.
    always_comb begin
        if (dt_cycles == '0) begin
            dt_eff = EXT_W'(1);
        end else begin
            dt_eff = {1'b0, dt_cycles};
        end
        elapsed = {1'b0, cnt_q} + EXT_W'(1);
        gap_met = (elapsed >= dt_eff);
    end

    // Counts completed idle cycles; saturates so a long idle stays satisfied.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold_clr) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + DT_W'(1);
        end
    end

endmodule

// File: rtl/hb_gate_interlock.sv
module hb_gate_interlock
    import hbd_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DT_W-1:0] dt_cycles,
    input  logic            hi_cmd,
    input  logic            lo_cmd_n,
    input  logic            shutdown_in,
    input  logic            uvlo_in,
    output logic            hi_gate,
    output logic            lo_gate
);

    hbd_state_e state_q;
    hbd_state_e state_d;
    hbd_req_e   req;
    logic       force_off;
    logic       gap_met;
    logic       gap_clr;

    assign force_off = shutdown_in | uvlo_in;
    assign gap_clr   = (state_q != ST_IDLE);

    hbd_req_decode u_decode (
        .hi_cmd   (hi_cmd),
        .lo_cmd_n (lo_cmd_n),
        .req      (req)
    );

    hbd_gap_timer #(
        .DT_W (DT_W)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_clr  (gap_clr),
        .dt_cycles (dt_cycles),
        .gap_met   (gap_met)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (force_off) begin
            state_d = ST_HALT;                         // trip
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (gap_met && (req == REQ_HI)) begin
                        state_d = ST_HI_ON;            // arm_hi
                    end else if (gap_met && (req == REQ_LO)) begin
                        state_d = ST_LO_ON;            // arm_lo
                    end
                end
                ST_HI_ON: begin
                    if (req != REQ_HI) begin
                        state_d = ST_IDLE;             // release_hi
                    end
                end
                ST_LO_ON: begin
                    if (req != REQ_LO) begin
                        state_d = ST_IDLE;             // release_lo
                    end
                end
                ST_HALT: begin
                    state_d = ST_IDLE;                 // resume
                end
                default: state_d = ST_HALT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: force-off gates them without waiting for an edge.
    always_comb begin
        hi_gate = 1'b0;
        lo_gate = 1'b0;
        unique case (state_q)
            ST_HI_ON: hi_gate = ~force_off;
            ST_LO_ON: lo_gate = ~force_off;
            ST_IDLE,
            ST_HALT:  begin
                hi_gate = 1'b0;
                lo_gate = 1'b0;
            end
            default:  begin
                hi_gate = 1'b0;
                lo_gate = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hb_gate_interlock_chk.sv
module hb_gate_interlock_chk #(
    parameter int DT_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DT_W-1:0] dt_cycles,
    input logic            hi_cmd,
    input logic            lo_cmd_n,
    input logic            shutdown_in,
    input logic            uvlo_in,
    input logic            hi_gate,
    input logic            lo_gate
);

    localparam int RUN_W = DT_W + 1;

    logic             force_any;
    logic [RUN_W-1:0] run_q;
    logic [DT_W-1:0]  dt_prev_q;
    logic [RUN_W-1:0] deff_prev;

    assign force_any = shutdown_in | uvlo_in;
    assign deff_prev = (dt_prev_q == '0) ? RUN_W'(1) : {1'b0, dt_prev_q};

    // Consecutive sampled edges with both gates low and no force-off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= '0;
            dt_prev_q <= '0;
        end else begin
            dt_prev_q <= dt_cycles;
            if (hi_gate || lo_gate || force_any) begin
                run_q <= '0;
            end else if (run_q != {RUN_W{1'b1}}) begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end

    // R4
    never_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_gate && lo_gate));

    // R8
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_any |-> (!hi_gate && !lo_gate));

    // R2
    clash_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cmd && !lo_cmd_n) |=> (!hi_gate && !lo_gate));

    // R3
    neutral_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_cmd && lo_cmd_n) |=> (!hi_gate && !lo_gate));

    // R1
    hi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_gate) |-> $past(hi_cmd && lo_cmd_n));

    // R1
    lo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_gate) |-> $past(!hi_cmd && !lo_cmd_n));

    // R5
    gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_gate) || $rose(lo_gate)) |-> (run_q >= deff_prev));

    // R9
    release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_any |-> ##2 (!hi_gate && !lo_gate));

endmodule

bind hb_gate_interlock hb_gate_interlock_chk #(.DT_W(DT_W)) u_chk (.*);

// File: tb/test_hb_gate_interlock.sv
module test_hb_gate_interlock;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DT_W = 4;

    logic            clk;
    logic            rst_n;
    logic [DT_W-1:0] dt_cycles;
    logic            hi_cmd;
    logic            lo_cmd_n;
    logic            shutdown_in;
    logic            uvlo_in;
    logic            hi_gate;
    logic            lo_gate;

    int    checks;
    int    errors;
    bit    done;
    int    edge_n;
    int    t_ref;
    bit    mh;
    bit    ml;
    string tag_ovr;

    hb_gate_interlock #(.DT_W(DT_W)) i_hb_gate_interlock (
        .clk         (clk),
        .rst_n       (rst_n),
        .dt_cycles   (dt_cycles),
        .hi_cmd      (hi_cmd),
        .lo_cmd_n    (lo_cmd_n),
        .shutdown_in (shutdown_in),
        .uvlo_in     (uvlo_in),
        .hi_gate     (hi_gate),
        .lo_gate     (lo_gate)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at edge %0d", tag, what, act, exp, edge_n);
        end
    endtask

    function automatic string pick_tag();
        if (tag_ovr != "") return tag_ovr;
        if (shutdown_in || uvlo_in) return "R8";
        if (hi_cmd && !lo_cmd_n) return "R2";
        if (!hi_cmd && lo_cmd_n) return "R3";
        if ((hi_cmd && lo_cmd_n && !mh) || (!hi_cmd && !lo_cmd_n && !ml))
            return (dt_cycles == 0) ? "R6" : "R5";
        return "R1";
    endfunction

    // Reference: edge k may turn a gate on only if k - t_ref >= D.
    task automatic model_edge();
        int k;
        int deff;
        k    = edge_n;
        deff = (dt_cycles == 0) ? 1 : int'(dt_cycles);
        if (shutdown_in || uvlo_in) begin
            mh    = 1'b0;
            ml    = 1'b0;
            t_ref = k + 1;
        end else if (mh) begin
            if (!(hi_cmd && lo_cmd_n)) begin
                mh    = 1'b0;
                t_ref = k;
            end
        end else if (ml) begin
            if (!(!hi_cmd && !lo_cmd_n)) begin
                ml    = 1'b0;
                t_ref = k;
            end
        end else if (k - t_ref >= deff) begin
            if (hi_cmd && lo_cmd_n) mh = 1'b1;
            else if (!hi_cmd && !lo_cmd_n) ml = 1'b1;
        end
        edge_n++;
    endtask

    task automatic compare();
        string tag;
        logic  frc;
        tag = pick_tag();
        frc = shutdown_in | uvlo_in;
        chk(tag, hi_gate, mh & ~frc, "hi_gate");
        chk(tag, lo_gate, ml & ~frc, "lo_gate");
        // R4: never both on
        chk("R4", hi_gate & lo_gate, 1'b0, "both_on");
    endtask

    task automatic step(input logic h, input logic ln);
        hi_cmd   = h;
        lo_cmd_n = ln;
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int dts[4];
        dts = '{0, 1, 2, 5};
        checks = 0; errors = 0; done = 1'b0;
        tag_ovr = "";
        rst_n = 1'b0; dt_cycles = 4'd3;
        hi_cmd = 1'b1; lo_cmd_n = 1'b1;
        shutdown_in = 1'b0; uvlo_in = 1'b0;
        mh = 1'b0; ml = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        // R11: gates low while reset held even with a request present
        chk("R11", hi_gate, 1'b0, "hi_gate in reset");
        chk("R11", lo_gate, 1'b0, "lo_gate in reset");

        // R11: first turn-on after release no earlier than D edges
        rst_n  = 1'b1;
        edge_n = 0;
        t_ref  = -1;
        tag_ovr = "R11";
        repeat (6) step(1'b1, 1'b1);
        tag_ovr = "";
        repeat (6) step(1'b0, 1'b1);

        // Sweep every pair of command combinations under several gaps
        foreach (dts[i]) begin
            dt_cycles = DT_W'(dts[i]);
            repeat (8) step(1'b0, 1'b1);
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int hv = 0; hv < 2; hv++) begin
                        int hold;
                        hold = (hv == 1) ? dts[i] + 3 : 1;
                        repeat (dts[i] + 3) step(a[1], a[0]);
                        repeat (hold) step(b[1], b[0]);
                        repeat (2) step(a[1], a[0]);
                    end
                end
            end
        end

        // R7: gap already elapsed -> first sampling edge turns gate on
        dt_cycles = 4'd3;
        repeat (6) step(1'b0, 1'b1);
        tag_ovr = "R7";
        step(1'b1, 1'b1);
        chk("R7", hi_gate, 1'b1, "hi_gate after long idle");
        repeat (5) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk("R7", lo_gate, 1'b1, "lo_gate after long idle");
        tag_ovr = "";

        // R10: single tied control signal, several pulse widths
        foreach (dts[i]) begin
            dt_cycles = DT_W'(dts[i]);
            tag_ovr = "R10";
            for (int w = 1; w < 8; w++) begin
                repeat (w) step(1'b1, 1'b1);
                repeat (w) step(1'b0, 1'b0);
            end
            tag_ovr = "";
        end

        // R6: zero gap gives exactly one idle cycle
        dt_cycles = 4'd0;
        repeat (4) step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        chk("R6", lo_gate, 1'b0, "lo_gate in idle cycle");
        chk("R6", hi_gate, 1'b0, "hi_gate in idle cycle");
        step(1'b0, 1'b0);
        chk("R6", lo_gate, 1'b1, "lo_gate after one idle");

        // R8 / R9: shutdown and undervoltage, each with two gaps
        for (int src = 0; src < 2; src++) begin
            for (int g = 0; g < 2; g++) begin
                dt_cycles = (g == 0) ? 4'd1 : 4'd4;
                repeat (8) step(src[0], src[0]);
                if (src == 0) shutdown_in = 1'b1;
                else          uvlo_in     = 1'b1;
                #1;
                chk("R8", hi_gate, 1'b0, "hi_gate same cycle");
                chk("R8", lo_gate, 1'b0, "lo_gate same cycle");
                tag_ovr = "R8";
                repeat (3) step(src[0], src[0]);
                shutdown_in = 1'b0;
                uvlo_in     = 1'b0;
                tag_ovr = "R9";
                repeat (7) step(src[0], src[0]);
                tag_ovr = "";
            end
        end

        repeat (3) step(1'b0, 1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule